// File: doc/BRIEF.md
# 16-bit Arithmetic and Logic Unit with Packed-Decimal Add

This block is the purely combinational execute stage of a 16-bit two-operand register machine. Each evaluation takes a source operand, a destination operand, the current carry bit from the status word, a 4-bit operation code and a byte-width select. It returns a result together with fresh negative, zero, carry and overflow flags. The surrounding pipeline handles decode, operand fetch, the register file and writeback. It reads the `noWriteback` output to learn that an operation only updates flags and must leave its destination untouched.

Subtraction reuses the binary adder: the source is inverted and the carry input is forced to one, or taken from the status carry for the borrow-chained form. For that form a carry of one means that no borrow is pending. A separate digit-serial chain adds packed decimal operands one nibble at a time. In byte mode every byte-capable operation works on bits 7:0 only. The high byte of the result is then cleared, and all four flags are taken from the 8-bit result.

Top module: `alu16_core`

## Requirements
- R1: Code 0 returns dst + src and code 1 returns dst + src + carryIn. flagC is the carry out of the operand width. flagV is set when the signed sum does not fit in the width.
- R2: Code 2 returns dst + NOT(src) + 1 and code 3 returns dst + NOT(src) + carryIn. flagC = 1 means no borrow occurred. flagV is set when the signed difference overflows.
- R3: Code 4 produces the same result and flags as code 2 and drives noWriteback high.
- R4: Code 5 adds src, dst and carryIn as packed decimal, 4 bits per digit. flagC is set when the true decimal sum exceeds 9999 (word) or 99 (byte). flagV is 0.
- R5: Code 6 returns src AND dst, code 7 returns NOT(src) AND dst, code 8 returns src OR dst, and code 10 returns src XOR dst. For these codes flagV is 0 and flagC is the inverse of flagZ.
- R6: Code 9 produces the flags of src AND dst (flagC = NOT flagZ, flagV = 0) and drives noWriteback high.
- R7: Code 11 shifts dst right by one while keeping its top bit. flagC takes the bit shifted out of bit 0, and flagV is 0.
- R8: Code 12 shifts dst right by one with carryIn entering the top bit. flagC takes the old bit 0, and flagV is 0.
- R9: Code 13 exchanges the two bytes of dst and code 14 copies dst bit 7 into bits 15:8. Both always work on 16 bits and ignore byteMode. flagC = NOT flagZ and flagV = 0.
- R10: For every code except 15, flagN equals the top bit of the active width (bit 15, or bit 7 in byte mode) and flagZ is set exactly when the result is zero.
- R11: With byteMode = 1, all byte-capable codes (0 to 12) ignore operand bits 15:8, return result bits 15:8 as zero and take every flag from the 8-bit result.
- R12: noWriteback is low for every code other than 4, 9 and 15.
- R13: Code 15 is reserved. It returns a zero result, clears all four flags and drives noWriteback high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcOp | input | 16 | Source operand |
| dstOp | input | 16 | Destination operand |
| carryIn | input | 1 | Carry bit from the status word |
| opCode | input | 4 | Operation code (0 to 15, see requirements) |
| byteMode | input | 1 | 1 selects 8-bit operation on bits 7:0 |
| result | output | 16 | Operation result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Signed overflow flag |
| noWriteback | output | 1 | High when the destination must not be written |

## Verification
The byte-width select and the carry chains act in the same evaluation. A byte operation has to cut the carry at bit 8 while nonzero high-byte operand bits would otherwise ripple a carry into bit 16. The bench provokes this by padding byte-mode operands with 0xFF and 0xA5 in their high bytes, together with low bytes that carry out (0x80 + 0x80, 0x99 + 0x01 decimal, 0x00 − 0x01). It judges the results by requiring flagC from the 8-bit boundary, a cleared result high byte and flags identical to those of the same low bytes with zero high bytes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,
    OP_BIT  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRA  = 4'd11,
    OP_RRC  = 4'd12,
    OP_SWPB = 4'd13,
    OP_SXT  = 4'd14,
    OP_NONE = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } carrySel_e;

  typedef enum logic [2:0] {
    RES_ADDER,
    RES_BCD,
    RES_LOGIC,
    RES_SHIFT,
    RES_SWAP,
    RES_SEXT,
    RES_ZERO
  } resSel_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_BIC,
    LOG_OR,
    LOG_XOR
  } logicSel_e;

  typedef enum logic [2:0] {
    FLG_ARITH,
    FLG_BCD,
    FLG_LOGIC,
    FLG_SHIFT,
    FLG_NONE
  } flagSel_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic      invertSrc;
    carrySel_e carrySel;
    resSel_e   resSel;
    logicSel_e logicSel;
    logic      rotateIn;
    logic      byteOp;
    flagSel_e  flagSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
  parameter int DIGITS      = 4,
  parameter int BYTE_DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] aIn,
  input  logic [4*DIGITS-1:0] bIn,
  input  logic                cIn,
  output logic [4*DIGITS-1:0] sumOut,
  output logic                byteCarry,
  output logic                wordCarry
);

  logic [DIGITS:0] chain;
  assign chain[0] = cIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] rawSum;
    logic       adjust;
    assign rawSum = {1'b0, aIn[4*d +: 4]} + {1'b0, bIn[4*d +: 4]} + {4'd0, chain[d]};
    // a digit above nine wraps by adding six and passes a decimal carry on
    assign adjust = (rawSum > 5'd9);
    assign sumOut[4*d +: 4] = adjust ? (rawSum[3:0] + 4'd6) : rawSum[3:0];
    assign chain[d+1] = adjust;
  end

  assign byteCarry = chain[BYTE_DIGITS];
  assign wordCarry = chain[DIGITS];

endmodule

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  aluOp_e   opSel,
  input  logic     byteMode,
  output aluCtrl_t ctrlBus,
  output logic     noWrite
);

  always_comb begin
    ctrlBus.invertSrc = 1'b0;
    ctrlBus.carrySel  = CIN_ZERO;
    ctrlBus.resSel    = RES_ZERO;
    ctrlBus.logicSel  = LOG_AND;
    ctrlBus.rotateIn  = 1'b0;
    ctrlBus.byteOp    = byteMode;
    ctrlBus.flagSel   = FLG_NONE;
    noWrite           = 1'b0;
    unique case (opSel)
      OP_ADD: begin
        ctrlBus.resSel  = RES_ADDER;
        ctrlBus.flagSel = FLG_ARITH;
      end
      OP_ADDC: begin
        ctrlBus.resSel   = RES_ADDER;
        ctrlBus.carrySel = CIN_FLAG;
        ctrlBus.flagSel  = FLG_ARITH;
      end
      OP_SUB, OP_CMP: begin
        ctrlBus.resSel    = RES_ADDER;
        ctrlBus.invertSrc = 1'b1;
        ctrlBus.carrySel  = CIN_ONE;
        ctrlBus.flagSel   = FLG_ARITH;
        noWrite           = (opSel == OP_CMP);
      end
      OP_SUBC: begin
        ctrlBus.resSel    = RES_ADDER;
        ctrlBus.invertSrc = 1'b1;
        ctrlBus.carrySel  = CIN_FLAG;
        ctrlBus.flagSel   = FLG_ARITH;
      end
      OP_DADD: begin
        ctrlBus.resSel  = RES_BCD;
        ctrlBus.flagSel = FLG_BCD;
      end
      OP_AND, OP_BIT: begin
        ctrlBus.resSel   = RES_LOGIC;
        ctrlBus.logicSel = LOG_AND;
        ctrlBus.flagSel  = FLG_LOGIC;
        noWrite          = (opSel == OP_BIT);
      end
      OP_BIC: begin
        ctrlBus.resSel   = RES_LOGIC;
        ctrlBus.logicSel = LOG_BIC;
        ctrlBus.flagSel  = FLG_LOGIC;
      end
      OP_BIS: begin
        ctrlBus.resSel   = RES_LOGIC;
        ctrlBus.logicSel = LOG_OR;
        ctrlBus.flagSel  = FLG_LOGIC;
      end
      OP_XOR: begin
        ctrlBus.resSel   = RES_LOGIC;
        ctrlBus.logicSel = LOG_XOR;
        ctrlBus.flagSel  = FLG_LOGIC;
      end
      OP_RRA: begin
        ctrlBus.resSel  = RES_SHIFT;
        ctrlBus.flagSel = FLG_SHIFT;
      end
      OP_RRC: begin
        ctrlBus.resSel   = RES_SHIFT;
        ctrlBus.rotateIn = 1'b1;
        ctrlBus.flagSel  = FLG_SHIFT;
      end
      OP_SWPB: begin
        ctrlBus.resSel  = RES_SWAP;
        ctrlBus.byteOp  = 1'b0;
        ctrlBus.flagSel = FLG_LOGIC;
      end
      OP_SXT: begin
        ctrlBus.resSel  = RES_SEXT;
        ctrlBus.byteOp  = 1'b0;
        ctrlBus.flagSel = FLG_LOGIC;
      end
      default: begin
        ctrlBus.byteOp = 1'b0;
        noWrite        = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic              carryIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int DIGITS = DATA_W / 4;

  logic [DATA_W-1:0] srcEff;
  logic              cinEff;
  logic [DATA_W:0]   wordSum;
  logic [BYTE_W:0]   byteSum;
  logic [DATA_W-1:0] bcdSum;
  logic              bcdByteCarry;
  logic              bcdWordCarry;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftMsbIn;
  logic [DATA_W-1:0] rawRes;
  logic              resMsb;
  logic              srcMsb;
  logic              dstMsb;
  logic              addCarry;

  // binary adder shared by add, subtract and compare
  assign srcEff  = ctrl.invertSrc ? ~srcOp : srcOp;

  always_comb begin
    unique case (ctrl.carrySel)
      CIN_ONE:  cinEff = 1'b1;
      CIN_FLAG: cinEff = carryIn;
      default:  cinEff = 1'b0;
    endcase
  end

  assign wordSum = {1'b0, dstOp} + {1'b0, srcEff} + {{DATA_W{1'b0}}, cinEff};
  assign byteSum = {1'b0, dstOp[BYTE_W-1:0]} + {1'b0, srcEff[BYTE_W-1:0]}
                 + {{BYTE_W{1'b0}}, cinEff};

  alu16_bcd #(
    .DIGITS      (DIGITS),
    .BYTE_DIGITS (BYTE_W / 4)
  ) bcd_i (
    .aIn       (srcOp),
    .bIn       (dstOp),
    .cIn       (carryIn),
    .sumOut    (bcdSum),
    .byteCarry (bcdByteCarry),
    .wordCarry (bcdWordCarry)
  );

  always_comb begin
    unique case (ctrl.logicSel)
      LOG_BIC: logicRes = ~srcOp & dstOp;
      LOG_OR:  logicRes = srcOp | dstOp;
      LOG_XOR: logicRes = srcOp ^ dstOp;
      default: logicRes = srcOp & dstOp;
    endcase
  end

  // right shift: rotate feeds the status carry, arithmetic keeps the sign bit
  always_comb begin
    if (ctrl.byteOp) begin
      shiftMsbIn = ctrl.rotateIn ? carryIn : dstOp[BYTE_W-1];
      shiftRes   = {{BYTE_W{1'b0}}, shiftMsbIn, dstOp[BYTE_W-1:1]};
    end else begin
      shiftMsbIn = ctrl.rotateIn ? carryIn : dstOp[DATA_W-1];
      shiftRes   = {shiftMsbIn, dstOp[DATA_W-1:1]};
    end
  end

  always_comb begin
    unique case (ctrl.resSel)
      RES_ADDER: rawRes = wordSum[DATA_W-1:0];
      RES_BCD:   rawRes = bcdSum;
      RES_LOGIC: rawRes = logicRes;
      RES_SHIFT: rawRes = shiftRes;
      RES_SWAP:  rawRes = {dstOp[BYTE_W-1:0], dstOp[DATA_W-1:BYTE_W]};
      RES_SEXT:  rawRes = {{BYTE_W{dstOp[BYTE_W-1]}}, dstOp[BYTE_W-1:0]};
      default:   rawRes = '0;
    endcase
    if (ctrl.byteOp) begin
      result = {{BYTE_W{1'b0}}, rawRes[BYTE_W-1:0]};
    end else begin
      result = rawRes;
    end
  end

  assign resMsb   = ctrl.byteOp ? result[BYTE_W-1] : result[DATA_W-1];
  assign srcMsb   = ctrl.byteOp ? srcEff[BYTE_W-1] : srcEff[DATA_W-1];
  assign dstMsb   = ctrl.byteOp ? dstOp[BYTE_W-1]  : dstOp[DATA_W-1];
  assign addCarry = ctrl.byteOp ? byteSum[BYTE_W]  : wordSum[DATA_W];

  always_comb begin
    flagN = resMsb;
    flagZ = (result == '0);
    flagC = 1'b0;
    flagV = 1'b0;
    unique case (ctrl.flagSel)
      FLG_ARITH: begin
        flagC = addCarry;
        flagV = (srcMsb == dstMsb) && (resMsb != dstMsb);
      end
      FLG_BCD:   flagC = ctrl.byteOp ? bcdByteCarry : bcdWordCarry;
      FLG_LOGIC: flagC = (result != '0);
      FLG_SHIFT: flagC = dstOp[0];
      default: begin
        flagN = 1'b0;
        flagZ = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic              carryIn,
  input  logic [3:0]        opCode,
  input  logic              byteMode,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              noWriteback
);

  aluOp_e   opSel;
  aluCtrl_t ctrlBus;

  assign opSel = aluOp_e'(opCode);

  alu16_ctrl ctrl_i (
    .opSel    (opSel),
    .byteMode (byteMode),
    .ctrlBus  (ctrlBus),
    .noWrite  (noWriteback)
  );

  alu16_datapath #(
    .DATA_W (DATA_W)
  ) dp_i (
    .srcOp   (srcOp),
    .dstOp   (dstOp),
    .carryIn (carryIn),
    .ctrl    (ctrlBus),
    .result  (result),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV)
  );

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int DATA_W = 16
) (
  input logic [3:0]        opCode,
  input logic              byteMode,
  input logic [DATA_W-1:0] result,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV,
  input logic              noWriteback
);

  localparam int BYTE_W = DATA_W / 2;

  logic wordOnly;
  logic logicClass;
  logic shiftClass;
  assign wordOnly   = (opCode == 4'd13) || (opCode == 4'd14) || (opCode == 4'd15);
  assign logicClass = ((opCode >= 4'd6) && (opCode <= 4'd10)) || (opCode == 4'd13) || (opCode == 4'd14);
  assign shiftClass = (opCode == 4'd11) || (opCode == 4'd12);

  always_comb begin
    if (opCode != 4'd15) begin
      a_r10_zero_flag: assert (flagZ == (result == '0))
        else $error("zero flag disagrees with result");
      a_r10_neg_flag: assert (flagN == ((byteMode && !wordOnly) ? result[BYTE_W-1] : result[DATA_W-1]))
        else $error("negative flag disagrees with result");
    end
    if (byteMode && !wordOnly) begin
      a_r11_high_byte_clear: assert (result[DATA_W-1:BYTE_W] == '0)
        else $error("byte result has nonzero high byte");
    end
    if (logicClass) begin
      a_r5_logic_flags: assert ((flagC == !flagZ) && !flagV)
        else $error("logic-class carry/overflow wrong");
    end
    if (shiftClass) begin
      a_r7_shift_no_overflow: assert (!flagV)
        else $error("shift raised overflow");
    end
    if (opCode == 4'd15) begin
      a_r13_reserved_quiet: assert ((result == '0) && !flagN && !flagZ && !flagC && !flagV && noWriteback)
        else $error("reserved code not quiet");
    end
    a_r12_writeback_gate: assert (noWriteback == ((opCode == 4'd4) || (opCode == 4'd9) || (opCode == 4'd15)))
      else $error("writeback gate wrong");
  end

endmodule

bind alu16_core alu16_core_chk #(.DATA_W(DATA_W)) chk_i (
  .opCode      (opCode),
  .byteMode    (byteMode),
  .result      (result),
  .flagN       (flagN),
  .flagZ       (flagZ),
  .flagC       (flagC),
  .flagV       (flagV),
  .noWriteback (noWriteback)
);

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;

  logic        clk = 1'b0;
  logic [15:0] srcOp = '0;
  logic [15:0] dstOp = '0;
  logic        carryIn = 1'b0;
  logic [3:0]  opCode = '0;
  logic        byteMode = 1'b0;
  logic [15:0] result;
  logic        flagN, flagZ, flagC, flagV, noWriteback;

  int  vecCount = 0;
  int  failCount = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  alu16_core dut_i (
    .srcOp       (srcOp),
    .dstOp       (dstOp),
    .carryIn     (carryIn),
    .opCode      (opCode),
    .byteMode    (byteMode),
    .result      (result),
    .flagN       (flagN),
    .flagZ       (flagZ),
    .flagC       (flagC),
    .flagV       (flagV),
    .noWriteback (noWriteback)
  );

  function automatic longint toSigned(input longint x, input longint top);
    return (x >= top) ? x - 2 * top : x;
  endfunction

  // independent model; packs {noWriteback, V, C, Z, N, result}
  function automatic logic [20:0] refModel(input int op, input logic [15:0] s,
                                           input logic [15:0] d, input logic c,
                                           input logic bm);
    int     w;
    longint mask, top, a, b, r, sv, cl, la, lb, place, dsum, lim;
    logic   cf, vf, nw, zf, nf;
    w    = (bm && op != 13 && op != 14 && op != 15) ? 8 : 16;
    mask = (longint'(1) << w) - 1;
    top  = longint'(1) << (w - 1);
    a    = longint'(d) & mask;
    b    = longint'(s) & mask;
    cl   = c ? 1 : 0;
    r = 0; cf = 1'b0; vf = 1'b0; nw = 1'b0;
    case (op)
      0, 1: begin
        if (op == 0) cl = 0;
        r  = a + b + cl;
        cf = (r > mask);
        sv = toSigned(a, top) + toSigned(b, top) + cl;
        vf = (sv >= top) || (sv < -top);
        r  = r & mask;
      end
      2, 3, 4: begin
        if (op != 3) cl = 1;
        r  = a + ((~b) & mask) + cl;
        cf = (r > mask);
        sv = toSigned(a, top) - toSigned(b, top) - (1 - cl);
        vf = (sv >= top) || (sv < -top);
        r  = r & mask;
        nw = (op == 4);
      end
      5: begin
        la = 0; lb = 0; place = 1;
        for (int i = 0; i < w / 4; i++) begin
          la += ((a >> (4 * i)) & 15) * place;
          lb += ((b >> (4 * i)) & 15) * place;
          place *= 10;
        end
        lim  = place;
        dsum = la + lb + cl;
        cf   = (dsum >= lim);
        dsum = dsum % lim;
        for (int i = 0; i < w / 4; i++) begin
          r |= (dsum % 10) << (4 * i);
          dsum = dsum / 10;
        end
      end
      6, 9: begin r = a & b; nw = (op == 9); end
      7:  r = ((~b) & mask) & a;
      8:  r = a | b;
      10: r = a ^ b;
      11: begin r = (a >> 1) | (a & top); cf = a[0]; end
      12: begin r = (a >> 1) | (c ? top : 0); cf = a[0]; end
      13: r = ((a & 255) << 8) | (a >> 8);
      14: r = (a & 128) != 0 ? ((a & 255) | 65280) : (a & 255);
      default: nw = 1'b1;
    endcase
    if (op >= 6 && op != 11 && op != 12 && op != 15) cf = (r != 0);
    zf = (op != 15) && (r == 0);
    nf = (op != 15) && ((r & top) != 0);
    return {nw, vf, cf, zf, nf, 16'(r)};
  endfunction

  task automatic applyVec(input int op, input logic [15:0] s, input logic [15:0] d,
                          input logic c, input logic bm, input string tag);
    logic [20:0] expVal;
    logic [20:0] gotVal;
    @(posedge clk);
    opCode   = 4'(op);
    srcOp    = s;
    dstOp    = d;
    carryIn  = c;
    byteMode = bm;
    @(negedge clk);
    expVal = refModel(op, s, d, c, bm);
    gotVal = {noWriteback, flagV, flagC, flagZ, flagN, result};
    vecCount++;
    if (gotVal !== expVal) begin
      failCount++;
      $display("FAIL %s op=%0d src=%h dst=%h c=%b byte=%b actual{nw,V,C,Z,N,res}=%h expected=%h",
               tag, op, s, d, c, bm, gotVal, expVal);
    end
  endtask

  task automatic testResetState();
    // all-zero inputs select code 0: 0 + 0 gives zero result with Z set (R1, R10)
    @(negedge clk);
    vecCount++;
    if ({noWriteback, flagV, flagC, flagZ, flagN, result} !== 21'h02_0000) begin
      failCount++;
      $display("FAIL R10 idle actual=%h expected=%h",
               {noWriteback, flagV, flagC, flagZ, flagN, result}, 21'h02_0000);
    end
  endtask

  task automatic testAddSub();
    applyVec(0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, "R1 add overflow");
    applyVec(0, 16'hFFFF, 16'h0001, 1'b1, 1'b0, "R1 add carry ignores C");
    applyVec(0, 16'h8000, 16'h8000, 1'b0, 1'b0, "R1 add neg overflow");
    applyVec(1, 16'hFFFF, 16'h0000, 1'b1, 1'b0, "R1 addc wrap");
    applyVec(1, 16'h1234, 16'h4321, 1'b1, 1'b0, "R1 addc plain");
    applyVec(2, 16'h0001, 16'h0000, 1'b0, 1'b0, "R2 sub borrow");
    applyVec(2, 16'h0001, 16'h8000, 1'b0, 1'b0, "R2 sub overflow");
    applyVec(2, 16'h1234, 16'h1234, 1'b0, 1'b0, "R2 sub equal");
    applyVec(3, 16'h0000, 16'h0000, 1'b0, 1'b0, "R2 subc borrow in");
    applyVec(3, 16'h0005, 16'h0007, 1'b1, 1'b0, "R2 subc no borrow");
    applyVec(3, 16'hFFFF, 16'h7FFF, 1'b1, 1'b0, "R2 subc overflow");
  endtask

  task automatic testCompare();
    applyVec(4, 16'h0001, 16'h0000, 1'b1, 1'b0, "R3 cmp less");
    applyVec(4, 16'h8000, 16'h7FFF, 1'b0, 1'b0, "R3 cmp overflow");
    applyVec(4, 16'hABCD, 16'hABCD, 1'b0, 1'b0, "R3 cmp equal");
  endtask

  task automatic testDecimal();
    applyVec(5, 16'h1234, 16'h5678, 1'b0, 1'b0, "R4 dadd carries");
    applyVec(5, 16'h9999, 16'h0000, 1'b1, 1'b0, "R4 dadd overflow");
    applyVec(5, 16'h5000, 16'h4999, 1'b0, 1'b0, "R4 dadd 9999");
    applyVec(5, 16'h0009, 16'h0009, 1'b1, 1'b0, "R4 dadd digit 19");
    applyVec(5, 16'h0000, 16'h0000, 1'b0, 1'b0, "R4 dadd zero");
  endtask

  task automatic testLogic();
    applyVec(6,  16'hF0F0, 16'hFF00, 1'b0, 1'b0, "R5 and");
    applyVec(6,  16'h0F0F, 16'hF0F0, 1'b1, 1'b0, "R5 and zero");
    applyVec(7,  16'h00FF, 16'h8FF0, 1'b0, 1'b0, "R5 bic");
    applyVec(8,  16'h0001, 16'h8000, 1'b0, 1'b0, "R5 bis");
    applyVec(10, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R5 xor zero");
    applyVec(10, 16'h8000, 16'hFFFF, 1'b0, 1'b0, "R5 xor neg inputs");
  endtask

  task automatic testBitTest();
    applyVec(9, 16'h8000, 16'h8001, 1'b0, 1'b0, "R6 bit set");
    applyVec(9, 16'h0002, 16'h0001, 1'b1, 1'b0, "R6 bit clear");
  endtask

  task automatic testShifts();
    applyVec(11, 16'h0000, 16'h8001, 1'b0, 1'b0, "R7 rra neg");
    applyVec(11, 16'h0000, 16'h7FFE, 1'b1, 1'b0, "R7 rra pos");
    applyVec(11, 16'h0000, 16'h0001, 1'b0, 1'b0, "R7 rra to zero");
    applyVec(12, 16'h0000, 16'h0001, 1'b1, 1'b0, "R8 rrc carry in");
    applyVec(12, 16'h0000, 16'h8000, 1'b0, 1'b0, "R8 rrc no carry");
    applyVec(12, 16'h0000, 16'h0001, 1'b0, 1'b0, "R8 rrc zero");
  endtask

  task automatic testSwapExtend();
    applyVec(13, 16'h0000, 16'h12AB, 1'b0, 1'b0, "R9 swpb");
    applyVec(13, 16'h0000, 16'h12AB, 1'b0, 1'b1, "R9 swpb ignores byte");
    applyVec(14, 16'h0000, 16'h0080, 1'b0, 1'b0, "R9 sxt neg");
    applyVec(14, 16'h0000, 16'hFF7F, 1'b1, 1'b1, "R9 sxt pos ignores byte");
    applyVec(14, 16'h0000, 16'hAB00, 1'b0, 1'b0, "R9 sxt zero");
  endtask

  task automatic testByteMode();
    applyVec(0,  16'hFF80, 16'hFF80, 1'b0, 1'b1, "R11 add byte carry");
    applyVec(0,  16'hA57F, 16'h0001, 1'b0, 1'b1, "R11 add byte overflow");
    applyVec(2,  16'hFF01, 16'hA500, 1'b0, 1'b1, "R11 sub byte borrow");
    applyVec(4,  16'h1280, 16'h3480, 1'b0, 1'b1, "R11 cmp byte equal");
    applyVec(5,  16'hFF99, 16'hA501, 1'b0, 1'b1, "R11 dadd byte carry");
    applyVec(5,  16'h0045, 16'h0054, 1'b0, 1'b1, "R4 dadd byte 99");
    applyVec(8,  16'hFF00, 16'hFF00, 1'b1, 1'b1, "R11 bis byte zero");
    applyVec(11, 16'h0000, 16'hFF81, 1'b0, 1'b1, "R11 rra byte");
    applyVec(12, 16'h0000, 16'h0102, 1'b1, 1'b1, "R11 rrc byte");
  endtask

  task automatic testWriteback();
    for (int op = 0; op < 16; op++) begin
      applyVec(op, 16'h0123, 16'h0456, 1'b1, 1'b0, "R12 writeback gate");
    end
    applyVec(15, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R13 reserved");
    applyVec(15, 16'h8000, 16'h0000, 1'b0, 1'b1, "R13 reserved byte");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 600; i++) begin
      int          op;
      logic [15:0] s, d;
      op = int'($urandom_range(0, 15));
      s  = 16'($urandom);
      d  = 16'($urandom);
      if (i % 7 == 0) s = 16'h7FFF;
      if (i % 11 == 0) d = 16'h8000;
      if (op == 5) begin
        for (int k = 0; k < 4; k++) begin
          s[4*k +: 4] = 4'($urandom_range(0, 9));
          d[4*k +: 4] = 4'($urandom_range(0, 9));
        end
      end
      applyVec(op, s, d, 1'($urandom), 1'($urandom), "R10 random");
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  initial begin
    testResetState();
    testAddSub();
    testCompare();
    testDecimal();
    testLogic();
    testBitTest();
    testShifts();
    testSwapExtend();
    testByteMode();
    testWriteback();
    testRandom();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

endmodule